// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler and APB Register Port

This block is a watchdog that software reaches through an APB slave port. A prescaler turns strobes from a reference timebase (`ref_stb`, one pulse per reference clock cycle) into periodic ticks. Software loads a down-counter by writing the load register. Each tick lowers the counter by two while the watchdog is enabled and no selected pause source is active. When the counter runs out, or when software sets the trigger bit, the block raises `wdt_rst_req` for one clock cycle. It also notes the cause in a two-bit reason register.

When the block raises a request it clears its own enable and counter in the same cycle. This returns it to an idle state, just as the requested reset would. It keeps its scratch words and its reason register. Only the external synchronous reset `rst` clears everything. Three pause sources can freeze the counter, and each has its own mask bit: halt of debug core 1, halt of debug core 0, and bus activity from the JTAG debugger. The prescaler's remaining count and its running flag can be read back.

Top module: `wdt_apb`

## Requirements
- R1: After `rst`, control reads 0x07000000 (all three pause masks set, enable clear, count 0), reason reads 0, every scratch word reads 0, and tick control reads 0x00000600 (cycles 0, tick enable bit 9 = 1, running bit 10 = 1, remaining count 0).
- R2: Every APB access completes with `pready` high and `pslverr` low. Read data appears in the access phase. Offset 0x04 (load) and any offset above 0x2C read as 0.
- R3: A write to offset 0x04 puts pwdata[23:0] straight into the counter, and control bits 23:0 read it back. A load in the same cycle as a tick takes priority, and the counter never wraps upward.
- R4: When control bit 30 (enable) is 1 and no pause is active, each tick lowers the counter by exactly 2.
- R5: When the enable bit is 0, ticks leave the counter unchanged.
- R6: Control bit 26 masks `dbg_halt[1]`, bit 25 masks `dbg_halt[0]` and bit 24 masks `jtag_busy`. Any set bit whose input is high freezes the counter. An active input whose bit is clear has no effect.
- R7: A counted tick that finds the counter at 0 or 1 sets the counter to 0. It raises `wdt_rst_req` for exactly one cycle, writes reason = 01 (bit 0 = timer), and clears the enable bit.
- R8: A control write with bit 31 = 1 raises `wdt_rst_req` for one cycle, writes reason = 10 (bit 1 = forced), clears enable and counter, and bit 31 reads back 0.
- R9: The eight 32-bit scratch words at 0x0C..0x28 (step 4) are readable and writable, and they keep their contents across a watchdog request.
- R10: Tick control at 0x2C holds cycles in bits 8:0 and enable in bit 9 (both read/write), running in bit 10, and remaining count in bits 19:11. While running, each strobe lowers the remaining count by 1. A strobe that finds it at 1 or 0 makes a tick and reloads it from cycles. While tick enable is 0, no ticks occur and the remaining count reloads from cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ref_stb | input | 1 | One-cycle strobe per reference timebase cycle |
| dbg_halt | input | 2 | Debug halt status of core 1 (bit 1) and core 0 (bit 0) |
| jtag_busy | input | 1 | JTAG debugger is using the bus fabric |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| wdt_rst_req | output | 1 | One-cycle chip reset request |

## Verification
The assertions check on every cycle that a request lasts a single cycle, that it always comes with the enable cleared and exactly one reason bit set, and that apart from a load the counter only holds, drops by two or falls to zero. Whether ticks occur at the right strobe count, how each pause mask pairs with its own input, and the exact value read back after expiry or a forced trigger can only be shown by the bench's scenarios. The same applies to scratch words surviving a request and to the prescaler's live remaining count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_CTRL  = 0;
  localparam int WORD_LOAD  = 1;
  localparam int WORD_CAUSE = 2;
  localparam int WORD_SCR0  = 3;
  localparam int BIT_TRIG   = 31;
  localparam int BIT_EN     = 30;
  localparam int BIT_PSE_HI = 26;
  localparam int BIT_PSE_LO = 24;
  localparam int CAUSE_W    = 2;
  localparam logic [CAUSE_W-1:0] CAUSE_TIMER  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_FORCED = 2'b10;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_stb,
  input  logic              tick_en,
  input  logic [TICK_W-1:0] cycles,
  output logic              tick,
  output logic [TICK_W-1:0] remain,
  output logic              running
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  assign tick = running && ref_stb && (remain <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      running <= 1'b0;
    end else begin
      running <= tick_en;
      if (!tick_en)
        remain <= cycles;
      else if (running && ref_stb)
        remain <= (remain <= ONE) ? cycles : remain - ONE;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_ok,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             force_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic step;
  assign step   = tick && run_ok && !load_we && !force_clr;
  assign expire = step && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (force_clr)
      cnt <= '0;
    else if (load_we)
      cnt <= load_val;
    else if (step)
      cnt <= expire ? '0 : cnt - TWO;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int TICK_W = 9,
  parameter int NSCR   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                expire,
  input  logic [TICK_W-1:0]   ps_remain,
  input  logic                ps_running,
  output logic                ctrl_en,
  output logic [2:0]          pause_q,
  output logic                load_we,
  output logic [CNT_W-1:0]    load_val,
  output logic                force_wr,
  output logic                tick_en,
  output logic [TICK_W-1:0]   tick_cycles,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic                req_q
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int SCR_IW = (NSCR > 1) ? $clog2(NSCR) : 1;
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(WORD_CTRL);
  localparam logic [IDX_W-1:0] I_LOAD  = IDX_W'(WORD_LOAD);
  localparam logic [IDX_W-1:0] I_CAUSE = IDX_W'(WORD_CAUSE);
  localparam logic [IDX_W-1:0] I_SCR0  = IDX_W'(WORD_SCR0);
  localparam logic [IDX_W-1:0] I_TICK  = IDX_W'(WORD_SCR0 + NSCR);

  logic [IDX_W-1:0]  word;
  logic              wr_acc, ctrl_wr, tick_wr, scr_hit;
  logic [SCR_IW-1:0] scr_sel;
  logic [DATA_W-1:0] scr [NSCR];
  logic [DATA_W-1:0] rd_next;
  logic [1:0]        unused_lsb;

  assign unused_lsb = paddr[1:0];
  assign word     = paddr[ADDR_W-1:2];
  assign wr_acc   = psel && penable && pwrite;
  assign ctrl_wr  = wr_acc && (word == I_CTRL);
  assign tick_wr  = wr_acc && (word == I_TICK);
  assign load_we  = wr_acc && (word == I_LOAD);
  assign load_val = pwdata[CNT_W-1:0];
  assign force_wr = ctrl_wr && pwdata[BIT_TRIG];
  assign scr_hit  = (word >= I_SCR0) && (word < I_TICK);
  assign scr_sel  = SCR_IW'(word - I_SCR0);

  // control, cause and request
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      pause_q <= 3'b111;
      cause_q <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= expire || force_wr;
      if (ctrl_wr)
        pause_q <= pwdata[BIT_PSE_HI:BIT_PSE_LO];
      if (expire || force_wr)
        ctrl_en <= 1'b0;
      else if (ctrl_wr)
        ctrl_en <= pwdata[BIT_EN];
      if (force_wr)
        cause_q <= CAUSE_FORCED;
      else if (expire)
        cause_q <= CAUSE_TIMER;
    end
  end

  // prescaler control
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_en     <= 1'b1;
      tick_cycles <= '0;
    end else if (tick_wr) begin
      tick_en     <= pwdata[TICK_W];
      tick_cycles <= pwdata[TICK_W-1:0];
    end
  end

  // scratch words: power-on reset only
  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scr[g] <= '0;
      else if (wr_acc && scr_hit && (scr_sel == SCR_IW'(g)))
        scr[g] <= pwdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (word == I_CTRL)
      rd_next = {1'b0, ctrl_en, 3'b000, pause_q, 24'(cnt)};
    else if (word == I_CAUSE)
      rd_next = DATA_W'(cause_q);
    else if (scr_hit)
      rd_next = scr[scr_sel];
    else if (word == I_TICK)
      rd_next = DATA_W'({ps_remain, ps_running, tick_en, tick_cycles});
  end

  // read data captured in the setup phase, valid in the access phase
  always_ff @(posedge clk) begin
    if (rst)
      prdata <= '0;
    else if (psel && !penable && !pwrite)
      prdata <= rd_next;
  end
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int TICK_W = 9,
  parameter int NSCR   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_stb,
  input  logic [1:0]        dbg_halt,
  input  logic              jtag_busy,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              wdt_rst_req
);
  logic [CNT_W-1:0]   cnt_q, load_val;
  logic               expire, tick, ps_running, tick_en;
  logic [TICK_W-1:0]  ps_remain, tick_cycles;
  logic               ctrl_en, load_we, force_wr, paused;
  logic [2:0]         pause_q;
  logic [CAUSE_W-1:0] cause_q;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign paused  = |(pause_q & {dbg_halt[1], dbg_halt[0], jtag_busy});

  wdt_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .tick_en(tick_en),
    .cycles(tick_cycles), .tick(tick), .remain(ps_remain), .running(ps_running)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run_ok(ctrl_en && !paused),
    .load_we(load_we), .load_val(load_val), .force_clr(force_wr),
    .cnt(cnt_q), .expire(expire)
  );

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_W(TICK_W), .NSCR(NSCR)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt(cnt_q),
    .expire(expire), .ps_remain(ps_remain), .ps_running(ps_running),
    .ctrl_en(ctrl_en), .pause_q(pause_q), .load_we(load_we),
    .load_val(load_val), .force_wr(force_wr), .tick_en(tick_en),
    .tick_cycles(tick_cycles), .cause_q(cause_q), .req_q(wdt_rst_req)
  );
endmodule

// File: rtl/wdt_apb_checker.sv
module wdt_apb_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       cause,
  input logic             load_we,
  input logic             force_wr
);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  a_r7_req_pulse: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);

  a_r7_req_clears_en: assert property (@(posedge clk) disable iff (rst)
    req |-> !en);

  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (rst)
    req |-> ($countones(cause) == 1));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en && !load_we && !force_wr) |=> $stable(cnt));

  a_r4_step_two: assert property (@(posedge clk) disable iff (rst)
    (!load_we && !force_wr) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - TWO || cnt == '0));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !load_we |=> (cnt <= $past(cnt)));
endmodule

bind wdt_apb wdt_apb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req(wdt_rst_req), .en(ctrl_en), .cnt(cnt_q),
  .cause(cause_q), .load_we(load_we), .force_wr(force_wr)
);

// File: tb/wdt_apb_test.sv
module wdt_apb_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_stb = 1'b0;
  logic [1:0]  dbg_halt = 2'b00;
  logic        jtag_busy = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, wdt_rst_req;

  int tests = 0, fails = 0;
  int req_cnt = 0;
  logic req_prev = 1'b0;
  bit  req_long = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  wdt_apb uut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .dbg_halt(dbg_halt),
    .jtag_busy(jtag_busy), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  // monitor: compares read data in the access phase, tracks requests
  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_rst_req) req_cnt++;
      if (wdt_rst_req && req_prev) req_long = 1'b1;
      req_prev = wdt_rst_req;
    end
    if (psel && penable) begin
      check("R2 handshake", {30'b0, pready, pslverr}, 32'h2);
      if (!pwrite) begin
        if (exp_q.size() == 0) check("scoreboard empty", 32'h1, 32'h0);
        else check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1; penable = 1'b1;
    @(posedge clk); #1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1; penable = 1'b1;
    @(posedge clk); #1; psel = 1'b0; penable = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; ref_stb = 1'b1;
      @(posedge clk); #1; ref_stb = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);

    // R1 reset state
    apb_rd(8'h00, 32'h0700_0000, "R1 ctrl reset");
    apb_rd(8'h08, 32'h0, "R1 reason reset");
    apb_rd(8'h0C, 32'h0, "R1 scratch reset");
    apb_rd(8'h2C, 32'h0000_0600, "R1 tick reset");
    // R2 unmapped and load read 0
    apb_rd(8'h3C, 32'h0, "R2 unmapped");
    apb_rd(8'h04, 32'h0, "R2 load reads 0");

    // R10 prescaler to 3 cycles from a clean reload
    apb_wr(8'h2C, 32'h0000_0003);
    apb_wr(8'h2C, 32'h0000_0203);
    apb_rd(8'h2C, 32'h0000_1E03, "R10 tick reg loaded");

    // R3 load, R5 disabled hold
    apb_wr(8'h04, 32'h0000_0064);
    apb_rd(8'h00, 32'h0700_0064, "R3 load readback");
    strobes(1);
    apb_rd(8'h2C, 32'h0000_1603, "R10 remaining count");
    strobes(2);
    apb_rd(8'h00, 32'h0700_0064, "R5 hold while disabled");

    // R4 decrement by two per tick
    apb_wr(8'h00, 32'h4700_0000);
    strobes(3);
    apb_rd(8'h00, 32'h4700_0062, "R4 one tick");
    strobes(6);
    apb_rd(8'h00, 32'h4700_005E, "R4 two ticks");

    // R6 pause sources and masks
    dbg_halt = 2'b01;
    strobes(3);
    apb_rd(8'h00, 32'h4700_005E, "R6 core0 pause");
    apb_wr(8'h00, 32'h4500_0000);
    strobes(3);
    apb_rd(8'h00, 32'h4500_005C, "R6 core0 masked");
    dbg_halt = 2'b00; jtag_busy = 1'b1;
    strobes(3);
    apb_rd(8'h00, 32'h4500_005C, "R6 jtag pause");
    jtag_busy = 1'b0; dbg_halt = 2'b10;
    strobes(3);
    apb_rd(8'h00, 32'h4500_005C, "R6 core1 pause");
    dbg_halt = 2'b00;

    // R9 scratch written before requests
    apb_wr(8'h0C, 32'hDEAD_BEEF);
    apb_wr(8'h28, 32'h1234_5678);
    apb_rd(8'h0C, 32'hDEAD_BEEF, "R9 scratch0 rw");
    apb_rd(8'h28, 32'h1234_5678, "R9 scratch7 rw");

    // R7 expiry from a count of 3
    apb_wr(8'h04, 32'h0000_0003);
    strobes(3);
    apb_rd(8'h00, 32'h4500_0001, "R7 count at one");
    check("R7 no request yet", req_cnt, 0);
    strobes(3);
    apb_rd(8'h00, 32'h0500_0000, "R7 saturated, enable cleared");
    apb_rd(8'h08, 32'h1, "R7 reason timer");
    check("R7 request count", req_cnt, 1);
    apb_rd(8'h0C, 32'hDEAD_BEEF, "R9 scratch kept after expiry");

    // R8 forced trigger
    apb_wr(8'h04, 32'h0000_0032);
    apb_wr(8'h00, 32'h4700_0000);
    apb_wr(8'h00, 32'hC700_0000);
    apb_rd(8'h00, 32'h0700_0000, "R8 trigger reads 0, cleared");
    apb_rd(8'h08, 32'h2, "R8 reason forced");
    check("R8 request count", req_cnt, 2);
    apb_rd(8'h28, 32'h1234_5678, "R9 scratch kept after force");

    // R10 tick generator disabled
    apb_wr(8'h2C, 32'h0000_0003);
    apb_wr(8'h04, 32'h0000_000A);
    apb_wr(8'h00, 32'h4700_0000);
    strobes(6);
    apb_rd(8'h00, 32'h4700_000A, "R10 no ticks when off");
    apb_rd(8'h2C, 32'h0000_1803, "R10 stopped status");
    // R10 one-cycle period after reload from 3
    apb_wr(8'h2C, 32'h0000_0201);
    strobes(4);
    apb_rd(8'h00, 32'h4700_0006, "R10 period one");

    check("R7 single-cycle request", {31'b0, req_long}, 32'h0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule